// File: doc/BRIEF.md
# Prioritized Interrupt Controller for an 8-bit CPU Core

This block sits next to a small 8-bit processor core and decides when the core must break off normal execution to service a request. It holds a request-flag register, an enable-mask register and a master enable bit. Peripherals raise requests with single-cycle pulses, and software can also raise or drop requests by writing the flag register. The lowest-numbered request that is both flagged and enabled wins, and the block presents that request's service address to the core.

The core reports its own control events as strobes: enable-interrupts, disable-interrupts, return-with-enable and the end of each instruction. Taking an interrupt clears the master enable. Only the return-with-enable strobe, or a new enable command, sets it again. The block also drives a wake line that releases a halted core whenever an enabled request is pending, whatever the state of the master enable.

The dispatch path is a valid/ready pair. `irq_valid` is high while a dispatch is wanted, and `irq_vector` names the winner. The core accepts by raising `irq_ack` in a cycle where `irq_valid` is high. `irq_valid` may drop, and `irq_vector` may change, before the core accepts, because a higher-priority request can arrive or a DI command can land. The core must therefore sample both signals only in the accepting cycle. `irq_ack` has no effect while `irq_valid` is low.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the flag register reads 0xE0, the mask reads 0x00, and `master_en`, `irq_valid` and `wake` are all 0.
- R2: A pulse on `periph_req[i]` sets flag bit i at the next clock edge. Flag bits 7:5 always read as 1, so a register holding only bit 2 reads 0xE4.
- R3: A write with `reg_sel`=0 loads flag bits 4:0 from `reg_wdata`. Writing a 1 raises that request the same way a peripheral does, and writing a 0 clears it.
- R4: A write with `reg_sel`=1 loads mask bits 4:0. The mask reads back with bits 7:5 equal to 0.
- R5: `irq_valid` is 1 only when `master_en` is 1 and (flag & mask) over bits 4:0 is non-zero.
- R6: The winner is the lowest set bit of (flag & mask), and `irq_vector` = 0x40 + 8 × index. Bit 2 (timer) gives 0x50.
- R7: On a cycle with `irq_valid` and `irq_ack` both high, `master_en` clears and the winning flag bit clears, while the other flag bits are kept. `irq_ack` with `irq_valid` low changes nothing.
- R8: If `periph_req[i]` fires in the same cycle that bit i is cleared by an accepted dispatch, the bit stays set.
- R9: `cmd_di` clears `master_en` at the next edge. While `master_en` is 0, requests stay latched in the flag register and no dispatch is offered.
- R10: After `cmd_ei`, `master_en` becomes 1 at the first `instr_done` strobe that comes in a later cycle than the `cmd_ei` strobe.
- R11: `cmd_reti` sets `master_en` at the next edge. Instruction completions without `cmd_reti` or an enable command leave it at 0.
- R12: `wake` is 1 exactly when (flag & mask) over bits 4:0 is non-zero, whether `master_en` is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| periph_req | input | 5 | Single-cycle request pulses, one bit per source |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Selects the register: 0 for the flag register, 1 for the mask |
| reg_wdata | input | 8 | Write data |
| flag_rdata | output | 8 | Flag register read value, with bits 7:5 reading 1 |
| mask_rdata | output | 8 | Mask register read value, with bits 7:5 reading 0 |
| cmd_ei | input | 1 | Enable-interrupts command strobe |
| cmd_di | input | 1 | Disable-interrupts command strobe |
| cmd_reti | input | 1 | Return-with-enable command strobe |
| instr_done | input | 1 | Instruction-boundary strobe |
| irq_valid | output | 1 | A dispatch is wanted |
| irq_ack | input | 1 | Core accepts the dispatch (ready) |
| irq_vector | output | 8 | Service address of the winning request |
| master_en | output | 1 | Current master enable |
| wake | output | 1 | Releases a halted core |

## Verification
The bench targets the enable delay: a design that enables at once would offer a dispatch straight after `cmd_ei`, or in the same cycle as the EI instruction's own completion strobe. It checks that a dispatch leaves the master enable cleared across plain instruction completions, which a design that restores it on any return would get wrong. It drives a peripheral pulse onto a bit in the very cycle that bit is cleared by a dispatch, which exposes a design that lets the clear win and loses the request. It also checks that priority and vectors are right with several sources flagged, that `irq_ack` without `irq_valid` is ignored, and that `wake` rises while the master enable is 0.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    SEL_FLAG   = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;

  localparam int DEF_NUM_SRC     = 5;
  localparam int DEF_DATA_W      = 8;
  localparam int DEF_VEC_W       = 8;
  localparam int DEF_VEC_BASE    = 'h40;
  localparam int DEF_STRIDE_LOG2 = 3;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NUM_SRC = irq_pkg::DEF_NUM_SRC,
  parameter int DATA_W  = irq_pkg::DEF_DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req,
  input  logic               wr_flag,
  input  logic               wr_mask,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] flags,
  output logic [NUM_SRC-1:0] mask
);
  logic [NUM_SRC-1:0] flags_n;

  // A software write overrides the dispatch clear; a fresh request always wins.
  always_comb begin
    flags_n = wr_flag ? wdata[NUM_SRC-1:0] : (flags & ~clr);
    flags_n = flags_n | req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      mask  <= '0;
    end else begin
      flags <= flags_n;
      if (wr_mask) mask <= wdata[NUM_SRC-1:0];
    end
  end

  // R2
  req_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |=> ((flags & $past(req)) == $past(req)));

  // R4
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask == $past(wdata[NUM_SRC-1:0])));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_SRC     = irq_pkg::DEF_NUM_SRC,
  parameter int VEC_W       = irq_pkg::DEF_VEC_W,
  parameter int VEC_BASE    = irq_pkg::DEF_VEC_BASE,
  parameter int STRIDE_LOG2 = irq_pkg::DEF_STRIDE_LOG2
) (
  input  logic [NUM_SRC-1:0] pend,
  output logic [NUM_SRC-1:0] grant,
  output logic               any,
  output logic [VEC_W-1:0]   vector
);
  logic [NUM_SRC:0] blocked;

  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
    assign grant[i]     = pend[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | pend[i];
  end

  assign any = blocked[NUM_SRC];

  always_comb begin
    vector = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant[i]) vector = vector | VEC_W'(VEC_BASE + (i << STRIDE_LOG2));
    end
  end
endmodule

// File: rtl/irq_master_en.sv
module irq_master_en (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_ei,
  input  logic cmd_di,
  input  logic cmd_reti,
  input  logic instr_done,
  input  logic taken,
  output logic ime
);
  logic ei_armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ime      <= 1'b0;
      ei_armed <= 1'b0;
    end else begin
      if (cmd_di || taken)              ime <= 1'b0;
      else if (cmd_reti)                ime <= 1'b1;
      else if (ei_armed && instr_done)  ime <= 1'b1;

      if (cmd_di || taken)              ei_armed <= 1'b0;
      else if (cmd_ei)                  ei_armed <= 1'b1;
      else if (instr_done)              ei_armed <= 1'b0;
    end
  end

  // R9
  di_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_di |=> !ime);

  // R10 / R11
  ime_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ime) |-> ($past(cmd_reti) || ($past(ei_armed) && $past(instr_done))));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int NUM_SRC     = irq_pkg::DEF_NUM_SRC,
  parameter int DATA_W      = irq_pkg::DEF_DATA_W,
  parameter int VEC_W       = irq_pkg::DEF_VEC_W,
  parameter int VEC_BASE    = irq_pkg::DEF_VEC_BASE,
  parameter int STRIDE_LOG2 = irq_pkg::DEF_STRIDE_LOG2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] periph_req,
  input  logic               reg_wr,
  input  logic               reg_sel,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  flag_rdata,
  output logic [DATA_W-1:0]  mask_rdata,
  input  logic               cmd_ei,
  input  logic               cmd_di,
  input  logic               cmd_reti,
  input  logic               instr_done,
  output logic               irq_valid,
  input  logic               irq_ack,
  output logic [VEC_W-1:0]   irq_vector,
  output logic               master_en,
  output logic               wake
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] flags, mask, pend, grant, clr;
  logic               any_pend, fire, wr_flag, wr_mask;

  assign wr_flag = reg_wr && (reg_sel == irq_pkg::SEL_FLAG);
  assign wr_mask = reg_wr && (reg_sel == irq_pkg::SEL_ENABLE);
  assign pend    = flags & mask;
  assign fire    = irq_valid & irq_ack;
  assign clr     = grant & {NUM_SRC{fire}};

  irq_flag_bank #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .req(periph_req), .wr_flag(wr_flag),
    .wr_mask(wr_mask), .wdata(reg_wdata), .clr(clr),
    .flags(flags), .mask(mask)
  );

  irq_prio_pick #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE),
                  .STRIDE_LOG2(STRIDE_LOG2)) u_pick (
    .pend(pend), .grant(grant), .any(any_pend), .vector(irq_vector)
  );

  irq_master_en u_ime (
    .clk(clk), .rst_n(rst_n), .cmd_ei(cmd_ei), .cmd_di(cmd_di),
    .cmd_reti(cmd_reti), .instr_done(instr_done), .taken(fire), .ime(master_en)
  );

  assign irq_valid  = master_en & any_pend;
  assign wake       = any_pend;
  assign flag_rdata = {{PAD_W{1'b1}}, flags};
  assign mask_rdata = {{PAD_W{1'b0}}, mask};

  // R7
  take_clears_ime_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !master_en);

  // R7
  take_clears_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !wr_flag && ((periph_req & grant) == '0)) |=> ((flags & $past(grant)) == '0));

  // R8
  req_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ((periph_req & grant) != '0)) |=> ((flags & $past(grant)) != '0));
endmodule

// File: tb/irq_ctrl_tb_top.sv
module irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] periph_req = '0;
  logic       reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] flag_rdata, mask_rdata, irq_vector;
  logic       cmd_ei = 1'b0, cmd_di = 1'b0, cmd_reti = 1'b0, instr_done = 1'b0;
  logic       irq_valid, irq_ack = 1'b0, master_en, wake;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .flag_rdata(flag_rdata),
    .mask_rdata(mask_rdata), .cmd_ei(cmd_ei), .cmd_di(cmd_di),
    .cmd_reti(cmd_reti), .instr_done(instr_done), .irq_valid(irq_valid),
    .irq_ack(irq_ack), .irq_vector(irq_vector), .master_en(master_en),
    .wake(wake)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic write_reg(input logic sel, input logic [7:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_req(input logic [4:0] r);
    periph_req = r;
    @(negedge clk);
    periph_req = '0;
  endtask

  task automatic t_reset();
    check(flag_rdata, 8'hE0, "R1 flag reset");
    check(mask_rdata, 8'h00, "R1 mask reset");
    check(master_en, 1'b0, "R1 ime reset");
    check(irq_valid, 1'b0, "R1 valid reset");
    check(wake, 1'b0, "R1 wake reset");
  endtask

  task automatic t_mask();
    write_reg(1'b1, 8'hFF);
    check(mask_rdata, 8'h1F, "R4 mask upper bits read 0");
    write_reg(1'b1, 8'h04);
    check(mask_rdata, 8'h04, "R4 mask load");
  endtask

  task automatic t_periph_wake();
    pulse_req(5'b00100);
    check(flag_rdata, 8'hE4, "R2 timer request reads E4");
    check(wake, 1'b1, "R12 wake with ime clear");
    check(irq_valid, 1'b0, "R5 no dispatch while ime clear");
  endtask

  task automatic t_di_latch();
    cmd_di = 1'b1; idle(); cmd_di = 1'b0;
    idle();
    check(master_en, 1'b0, "R9 ime clear after di");
    check(irq_valid, 1'b0, "R9 no dispatch");
    check(flag_rdata, 8'hE4, "R9 request stays latched");
  endtask

  task automatic t_ack_ignored();
    irq_ack = 1'b1; idle(); irq_ack = 1'b0;
    check(flag_rdata, 8'hE4, "R7 ack without valid ignored");
    check(master_en, 1'b0, "R7 ime untouched by stray ack");
  endtask

  task automatic t_ei_delay();
    cmd_ei = 1'b1; instr_done = 1'b1; idle(); cmd_ei = 1'b0; instr_done = 1'b0;
    check(master_en, 1'b0, "R10 ime not set by ei own completion");
    idle();
    check(irq_valid, 1'b0, "R10 no dispatch before next boundary");
    instr_done = 1'b1; idle(); instr_done = 1'b0;
    check(master_en, 1'b1, "R10 ime set after following instruction");
    check(irq_valid, 1'b1, "R5 dispatch offered");
    check(irq_vector, 8'h50, "R6 timer vector");
  endtask

  task automatic t_take_plain_ret();
    irq_ack = 1'b1; idle(); irq_ack = 1'b0;
    check(master_en, 1'b0, "R7 ime cleared on take");
    check(flag_rdata, 8'hE0, "R7 serviced bit cleared");
    check(irq_valid, 1'b0, "R7 valid drops");
    instr_done = 1'b1; idle(); idle(); idle(); instr_done = 1'b0;
    check(master_en, 1'b0, "R11 plain return keeps ime clear");
  endtask

  task automatic t_reti();
    cmd_reti = 1'b1; idle(); cmd_reti = 1'b0;
    check(master_en, 1'b1, "R11 reti sets ime");
  endtask

  task automatic t_priority();
    write_reg(1'b1, 8'h1F);
    write_reg(1'b0, 8'h18);
    check(flag_rdata, 8'hF8, "R3 software raise");
    check(irq_valid, 1'b1, "R3 software request dispatches");
    check(irq_vector, 8'h58, "R6 lowest of bits 3,4");
    pulse_req(5'b00010);
    check(irq_vector, 8'h48, "R6 bit1 preempts");
    irq_ack = 1'b1; idle(); irq_ack = 1'b0;
    check(flag_rdata, 8'hF8, "R7 only winner cleared");
    cmd_reti = 1'b1; idle(); cmd_reti = 1'b0;
    check(irq_vector, 8'h58, "R6 next winner after return");
  endtask

  task automatic t_collision();
    periph_req = 5'b01000; irq_ack = 1'b1; idle();
    periph_req = '0; irq_ack = 1'b0;
    check(flag_rdata, 8'hF8, "R8 new request survives clear");
    check(master_en, 1'b0, "R8 take still clears ime");
  endtask

  task automatic t_mask_block();
    cmd_reti = 1'b1; idle(); cmd_reti = 1'b0;
    write_reg(1'b1, 8'h00);
    write_reg(1'b0, 8'h04);
    check(irq_valid, 1'b0, "R5 masked request not offered");
    check(wake, 1'b0, "R12 masked request no wake");
    write_reg(1'b0, 8'h00);
    check(flag_rdata, 8'hE0, "R3 software clear");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(); idle();
    rst_n = 1'b1;
    idle();
    t_reset();
    t_mask();
    t_periph_wake();
    t_di_latch();
    t_ack_ignored();
    t_ei_delay();
    t_take_plain_ret();
    t_reti();
    t_priority();
    t_collision();
    t_mask_block();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule